// File: doc/BRIEF.md
# Host-Side Keyboard and Pointer Controller Core

This block is the host-facing core of a two-device keyboard controller. A byte-wide bus with a single address bit reaches it. With the address bit at 0, reads return received bytes and writes carry data. With the address bit at 1, reads return a status byte and writes issue single-byte controller commands. The block keeps three registers: mode, status and output port. It holds one received byte for each attached device. It drives a keyboard interrupt and a pointer (aux) interrupt, an A20 gate line and a CPU reset pulse.

The devices connect through plain byte streams. Each device delivers bytes as a one-cycle valid with a byte. The core sends bytes to each device the same way. Some commands arm a one-shot redirect, which sends the next data write to the mode register, the output port, one of the receive buffers or the aux device instead of the keyboard. Keyboard bytes take precedence over aux bytes, both for reads and for interrupts. Line-level serial signalling and scan-code translation sit outside this core.

Top module: `kbc_core`

## Requirements
- R1: After reset, the mode register reads 0x03, the status byte reads 0x18, and the output port reads 0xCF. The A20 output is high and both interrupts are low.
- R2: Status layout: bit 0 = a received byte is waiting, bit 2 = self-test passed, bit 3 = 1, bit 4 = 1, bit 5 = only an aux byte is waiting. Bits 1, 6 and 7 are 0. Output-port bits 4 and 5 mirror status bits 0 and 5.
- R3: Command 0x20 queues the mode byte and command 0xD0 queues the output-port value, both as keyboard-side bytes. Command 0xC0 queues 0x80. Commands 0xA9 and 0xAB queue 0x00. Command 0xAA queues 0x55 and sets status bit 2.
- R4: These commands queue nothing. Each arms the next data write toward one target: 0x60 to the mode register, 0xD1 to the output port, 0xD2 to the keyboard receive buffer, 0xD3 to the aux receive buffer, and 0xD4 to the aux transmit stream. Any data write disarms the redirect. A data write with no redirect armed goes to the keyboard transmit stream.
- R5: Command 0xA7 sets mode bit 5 and 0xA8 clears it. Command 0xAD sets mode bit 4 and 0xAE clears it. The interrupt outputs follow the new mode on the next cycle.
- R6: A data read returns the aux byte only when the aux buffer alone holds a byte. In every other case it returns the keyboard byte. The read empties the buffer it was served from.
- R7: The keyboard interrupt is high while a keyboard byte waits, mode bit 0 is set and mode bit 4 is clear. The aux interrupt is high while only an aux byte waits and mode bit 1 is set.
- R8: Command 0xDF sets output-port bit 1 and command 0xDD clears it. The A20 output always follows output-port bit 1, and this includes values written through 0xD1.
- R9: A command with upper nibble 0xF and bit 0 clear, or an output-port write with bit 0 clear, raises the CPU reset output for exactly RESET_PULSE_CYCLES cycles. An upper-nibble-0xF command with bit 0 set does nothing.
- R10: A command byte not listed above changes no register, sends nothing and starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostAddr | input | 1 | 0 = data port, 1 = command/status port |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Read byte (combinational from state) |
| kbdRxValid | input | 1 | Keyboard byte arrives |
| kbdRxByte | input | 8 | Keyboard received byte |
| auxRxValid | input | 1 | Aux byte arrives |
| auxRxByte | input | 8 | Aux received byte |
| kbdTxValid | output | 1 | One-cycle strobe: byte for keyboard |
| kbdTxByte | output | 8 | Byte for keyboard |
| auxTxValid | output | 1 | One-cycle strobe: byte for aux device |
| auxTxByte | output | 8 | Byte for aux device |
| irqKbd | output | 1 | Keyboard interrupt level |
| irqAux | output | 1 | Aux interrupt level |
| a20Out | output | 1 | A20 gate level |
| cpuReset | output | 1 | CPU reset pulse, active high |

## Verification
The assertions assume that the host issues at most one access per cycle, never reading and writing in the same cycle. They also assume that a controller-generated byte never lands in the same cycle as a device byte for the same buffer. The bench meets both conditions: every access is a separate task call spanning its own clock cycle, and device bytes are injected only while no host access is in flight. The assertions also assume that a data read occurs only when a byte is waiting. The bench issues every data read after a step that has queued a byte.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MODE,
    RD_OUTP,
    RD_OBUF_KBD,
    RD_OBUF_AUX,
    RD_AUX_TX
  } redirect_e;

  typedef struct packed {
    logic       pushKbd;
    logic       pushAux;
    logic [7:0] pushByte;
    logic [7:0] wrByte;
    logic       modeWr;
    logic       setKbdDis;
    logic       clrKbdDis;
    logic       setAuxDis;
    logic       clrAuxDis;
    logic       outPortWr;
    logic       a20Set;
    logic       a20Clr;
    logic       selfTestSet;
    logic       kbdTx;
    logic       auxTx;
    logic       readData;
    logic       resetReq;
  } kbc_strobes_t;

endpackage

// File: rtl/kbc_ctrl.sv
module kbc_ctrl
  import kbc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostWr,
  input  logic         hostRd,
  input  logic         hostAddr,
  input  logic [7:0]   hostWdata,
  input  logic [7:0]   modeQ,
  input  logic [7:0]   outPortView,
  output kbc_strobes_t stb
);

  redirect_e redirQ, redirNext;

  always_comb begin
    stb        = '0;
    redirNext  = redirQ;
    stb.wrByte = hostWdata;
    stb.readData = hostRd && !hostAddr;
    if (hostWr && hostAddr) begin
      unique case (hostWdata)
        8'h20: begin stb.pushKbd = 1'b1; stb.pushByte = modeQ; end
        8'h60: redirNext = RD_MODE;
        8'hD1: redirNext = RD_OUTP;
        8'hD2: redirNext = RD_OBUF_KBD;
        8'hD3: redirNext = RD_OBUF_AUX;
        8'hD4: redirNext = RD_AUX_TX;
        8'hA7: stb.setAuxDis = 1'b1;
        8'hA8: stb.clrAuxDis = 1'b1;
        8'hA9, 8'hAB: begin stb.pushKbd = 1'b1; stb.pushByte = 8'h00; end
        8'hAA: begin
          stb.pushKbd     = 1'b1;
          stb.pushByte    = 8'h55;
          stb.selfTestSet = 1'b1;
        end
        8'hAD: stb.setKbdDis = 1'b1;
        8'hAE: stb.clrKbdDis = 1'b1;
        8'hC0: begin stb.pushKbd = 1'b1; stb.pushByte = 8'h80; end
        8'hD0: begin stb.pushKbd = 1'b1; stb.pushByte = outPortView; end
        8'hDD: stb.a20Clr = 1'b1;
        8'hDF: stb.a20Set = 1'b1;
        default: begin
          if (hostWdata[7:4] == 4'hF && !hostWdata[0]) stb.resetReq = 1'b1;
        end
      endcase
    end else if (hostWr && !hostAddr) begin
      unique case (redirQ)
        RD_NONE:     stb.kbdTx = 1'b1;
        RD_MODE:     stb.modeWr = 1'b1;
        RD_OUTP: begin
          stb.outPortWr = 1'b1;
          stb.resetReq  = !hostWdata[0];
        end
        RD_OBUF_KBD: begin stb.pushKbd = 1'b1; stb.pushByte = hostWdata; end
        RD_OBUF_AUX: begin stb.pushAux = 1'b1; stb.pushByte = hostWdata; end
        RD_AUX_TX:   stb.auxTx = 1'b1;
        default:     stb.kbdTx = 1'b1;
      endcase
      redirNext = RD_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) redirQ <= RD_NONE;
    else       redirQ <= redirNext;
  end

  // R4: a data write always leaves the redirect disarmed
  assert_redirect_oneshot_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !hostAddr) |=> (redirQ == RD_NONE));

  // R4: one host write feeds at most one destination
  assert_single_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.pushKbd, stb.pushAux, stb.kbdTx, stb.auxTx, stb.modeWr, stb.outPortWr}));

endmodule

// File: rtl/kbc_reset_pulse.sv
module kbc_reset_pulse #(
  parameter int PULSE_CYCLES = 300
) (
  input  logic clk,
  input  logic rstN,
  input  logic resetReq,
  output logic cpuReset
);

  localparam int CW = $clog2(PULSE_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)         cnt <= '0;
    else if (resetReq) cnt <= CW'(PULSE_CYCLES);
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign cpuReset = (cnt != 0);

  // R9: pulse starts only on a request, and every request starts one
  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuReset) |-> $past(resetReq));
  assert_pulse_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> cpuReset);

endmodule

// File: rtl/kbc_datapath.sv
module kbc_datapath
  import kbc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  kbc_strobes_t stb,
  input  logic         hostAddr,
  input  logic         kbdRxValid,
  input  logic [7:0]   kbdRxByte,
  input  logic         auxRxValid,
  input  logic [7:0]   auxRxByte,
  output logic [7:0]   modeQ,
  output logic [7:0]   outPortView,
  output logic [7:0]   hostRdata,
  output logic         irqKbd,
  output logic         irqAux,
  output logic         a20Out,
  output logic         kbdTxValid,
  output logic [7:0]   kbdTxByte,
  output logic         auxTxValid,
  output logic [7:0]   auxTxByte
);

  localparam logic [7:0] MODE_RST = 8'h03;
  localparam logic [7:0] OUTP_RST = 8'hCF;

  logic [7:0] outPortQ, kbdBuf, auxBuf;
  logic       kbdPend, auxPend, selfTestQ;
  logic       auxOnly, anyPend;
  logic [7:0] statusByte;

  assign anyPend = kbdPend || auxPend;
  assign auxOnly = auxPend && !kbdPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_RST;
    end else if (stb.modeWr) begin
      modeQ <= stb.wrByte;
    end else begin
      if (stb.setKbdDis) modeQ[4] <= 1'b1;
      if (stb.clrKbdDis) modeQ[4] <= 1'b0;
      if (stb.setAuxDis) modeQ[5] <= 1'b1;
      if (stb.clrAuxDis) modeQ[5] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPortQ <= OUTP_RST;
    end else if (stb.outPortWr) begin
      outPortQ <= stb.wrByte;
    end else if (stb.a20Set) begin
      outPortQ[1] <= 1'b1;
    end else if (stb.a20Clr) begin
      outPortQ[1] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                selfTestQ <= 1'b0;
    else if (stb.selfTestSet) selfTestQ <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kbdPend <= 1'b0;
      kbdBuf  <= '0;
    end else begin
      if (stb.readData && !auxOnly) kbdPend <= 1'b0;
      if (stb.pushKbd) begin
        kbdBuf  <= stb.pushByte;
        kbdPend <= 1'b1;
      end else if (kbdRxValid) begin
        kbdBuf  <= kbdRxByte;
        kbdPend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      auxPend <= 1'b0;
      auxBuf  <= '0;
    end else begin
      if (stb.readData && auxOnly) auxPend <= 1'b0;
      if (stb.pushAux) begin
        auxBuf  <= stb.pushByte;
        auxPend <= 1'b1;
      end else if (auxRxValid) begin
        auxBuf  <= auxRxByte;
        auxPend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kbdTxValid <= 1'b0;
      auxTxValid <= 1'b0;
      kbdTxByte  <= '0;
      auxTxByte  <= '0;
    end else begin
      kbdTxValid <= stb.kbdTx;
      auxTxValid <= stb.auxTx;
      if (stb.kbdTx) kbdTxByte <= stb.wrByte;
      if (stb.auxTx) auxTxByte <= stb.wrByte;
    end
  end

  assign statusByte  = {2'b00, auxOnly, 1'b1, 1'b1, selfTestQ, 1'b0, anyPend};
  assign outPortView = {outPortQ[7:6], auxOnly, anyPend, outPortQ[3:0]};
  assign hostRdata   = hostAddr ? statusByte : (auxOnly ? auxBuf : kbdBuf);
  assign a20Out      = outPortQ[1];
  assign irqKbd      = kbdPend && modeQ[0] && !modeQ[4];
  assign irqAux      = auxOnly && modeQ[1];

  // R6/R7: keyboard data masks the aux interrupt
  assert_kbd_priority_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqAux |-> !irqKbd);

  // R6: serving an aux-only read empties the aux buffer
  assert_aux_read_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.readData && auxOnly && !stb.pushAux && !auxRxValid) |=> !auxPend);

  // R8: gate-enable command raises the A20 line on the next cycle
  assert_a20_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.a20Set |=> a20Out);

  // R5: disabling the keyboard interface silences its interrupt next cycle
  assert_kbd_disable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setKbdDis && !stb.modeWr) |=> !irqKbd);

endmodule

// File: rtl/kbc_core.sv
module kbc_core #(
  parameter int RESET_PULSE_CYCLES = 300
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic       hostAddr,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  input  logic       kbdRxValid,
  input  logic [7:0] kbdRxByte,
  input  logic       auxRxValid,
  input  logic [7:0] auxRxByte,
  output logic       kbdTxValid,
  output logic [7:0] kbdTxByte,
  output logic       auxTxValid,
  output logic [7:0] auxTxByte,
  output logic       irqKbd,
  output logic       irqAux,
  output logic       a20Out,
  output logic       cpuReset
);

  kbc_pkg::kbc_strobes_t stb;
  logic [7:0] modeQ, outPortView;

  kbc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostWr     (hostWr),
    .hostRd     (hostRd),
    .hostAddr   (hostAddr),
    .hostWdata  (hostWdata),
    .modeQ      (modeQ),
    .outPortView(outPortView),
    .stb        (stb)
  );

  kbc_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .hostAddr   (hostAddr),
    .kbdRxValid (kbdRxValid),
    .kbdRxByte  (kbdRxByte),
    .auxRxValid (auxRxValid),
    .auxRxByte  (auxRxByte),
    .modeQ      (modeQ),
    .outPortView(outPortView),
    .hostRdata  (hostRdata),
    .irqKbd     (irqKbd),
    .irqAux     (irqAux),
    .a20Out     (a20Out),
    .kbdTxValid (kbdTxValid),
    .kbdTxByte  (kbdTxByte),
    .auxTxValid (auxTxValid),
    .auxTxByte  (auxTxByte)
  );

  kbc_reset_pulse #(.PULSE_CYCLES(RESET_PULSE_CYCLES)) u_pulse (
    .clk     (clk),
    .rstN    (rstN),
    .resetReq(stb.resetReq),
    .cpuReset(cpuReset)
  );

endmodule

// File: tb/kbc_core_tb.sv
module kbc_core_tb;

  localparam int PULSE = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWr = 1'b0, hostRd = 1'b0, hostAddr = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic kbdRxValid = 1'b0, auxRxValid = 1'b0;
  logic [7:0] kbdRxByte = '0, auxRxByte = '0;
  logic kbdTxValid, auxTxValid;
  logic [7:0] kbdTxByte, auxTxByte;
  logic irqKbd, irqAux, a20Out, cpuReset;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  kbc_core #(.RESET_PULSE_CYCLES(PULSE)) u_dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .kbdRxValid(kbdRxValid), .kbdRxByte(kbdRxByte),
    .auxRxValid(auxRxValid), .auxRxByte(auxRxByte),
    .kbdTxValid(kbdTxValid), .kbdTxByte(kbdTxByte),
    .auxTxValid(auxTxValid), .auxTxByte(auxTxByte),
    .irqKbd(irqKbd), .irqAux(irqAux), .a20Out(a20Out), .cpuReset(cpuReset)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every read cycle
  always @(negedge clk) begin
    if (hostRd) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard actual=%02h expected=none", hostRdata);
      end else begin
        chk(tagQ.pop_front(), hostRdata, expQ.pop_front());
      end
    end
  end

  task automatic cmd(logic [7:0] c);
    @(posedge clk); #1 hostWr = 1; hostAddr = 1; hostWdata = c;
    @(posedge clk); #1 hostWr = 0;
  endtask

  task automatic dwr(logic [7:0] d);
    @(posedge clk); #1 hostWr = 1; hostAddr = 0; hostWdata = d;
    @(posedge clk); #1 hostWr = 0;
  endtask

  task automatic rd(logic a, logic [7:0] exp, string tag);
    @(posedge clk); #1 expQ.push_back(exp); tagQ.push_back(tag);
    hostRd = 1; hostAddr = a;
    @(posedge clk); #1 hostRd = 0;
  endtask

  task automatic rx(logic k, logic [7:0] kb, logic a, logic [7:0] ab);
    @(posedge clk); #1 kbdRxValid = k; kbdRxByte = kb; auxRxValid = a; auxRxByte = ab;
    @(posedge clk); #1 kbdRxValid = 0; auxRxValid = 0;
  endtask

  // called right after the triggering write was captured
  task automatic pulseChk(logic expPulse, string tag);
    chk(tag, {7'b0, cpuReset}, {7'b0, expPulse});
    repeat (PULSE - 1) @(posedge clk);
    #1 chk(tag, {7'b0, cpuReset}, {7'b0, expPulse});
    @(posedge clk); #1 chk(tag, {7'b0, cpuReset}, 8'h00);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    rd(1, 8'h18, "R1 status");
    chk("R1 a20", {7'b0, a20Out}, 8'h01);
    chk("R1 irqs", {6'b0, irqKbd, irqAux}, 8'h00);
    cmd(8'h20); rd(1, 8'h19, "R2 obf"); rd(0, 8'h03, "R1 mode");
    cmd(8'hD0); rd(0, 8'hCF, "R1 outport");
    // R3 responses
    cmd(8'hAA); rd(1, 8'h1D, "R3 selftest status");
    chk("R7 irqKbd on", {7'b0, irqKbd}, 8'h01);
    rd(0, 8'h55, "R3 selftest byte"); rd(1, 8'h1C, "R2 empty");
    cmd(8'hA9); rd(0, 8'h00, "R3 aux test");
    cmd(8'hAB); rd(0, 8'h00, "R3 kbd test");
    cmd(8'hC0); rd(0, 8'h80, "R3 inport");
    // R6 priority
    rx(1, 8'h1C, 1, 8'h9A);
    rd(1, 8'h1D, "R6 kbd first status");
    chk("R6 irqs kbd", {6'b0, irqKbd, irqAux}, 8'h02);
    rd(0, 8'h1C, "R6 kbd byte");
    rd(1, 8'h3D, "R2 aux only status");
    chk("R7 irqs aux", {6'b0, irqKbd, irqAux}, 8'h01);
    rd(0, 8'h9A, "R6 aux byte"); rd(1, 8'h1C, "R6 drained");
    // R4 redirects
    cmd(8'hD3); dwr(8'h77); rd(1, 8'h3D, "R4 aux obuf"); rd(0, 8'h77, "R4 aux obuf byte");
    cmd(8'hD2); dwr(8'h42); rd(1, 8'h1D, "R4 kbd obuf"); rd(0, 8'h42, "R4 kbd obuf byte");
    cmd(8'hD4); dwr(8'hF4);
    chk("R4 aux tx valid", {6'b0, kbdTxValid, auxTxValid}, 8'h01);
    chk("R4 aux tx byte", auxTxByte, 8'hF4);
    dwr(8'hED);
    chk("R4 oneshot kbd tx", {6'b0, kbdTxValid, auxTxValid}, 8'h02);
    chk("R4 kbd tx byte", kbdTxByte, 8'hED);
    // R2 outport mirror with aux pending
    cmd(8'hD3); dwr(8'h55); cmd(8'hD0);
    rd(0, 8'hFF, "R2 outport mirror"); rd(0, 8'h55, "R6 aux after kbd");
    // R7 mode gating
    cmd(8'h60); dwr(8'h00); rx(1, 8'h11, 0, 8'h00);
    chk("R7 irqKbd masked", {7'b0, irqKbd}, 8'h00);
    rd(0, 8'h11, "R6 kbd byte");
    cmd(8'h20); rd(0, 8'h00, "R4 mode written");
    cmd(8'h60); dwr(8'h01); cmd(8'hD3); dwr(8'h66);
    chk("R7 irqAux masked", {6'b0, irqKbd, irqAux}, 8'h00);
    rd(0, 8'h66, "R6 aux byte");
    cmd(8'h60); dwr(8'h03);
    // R5 enable/disable
    cmd(8'hAD); rx(1, 8'h22, 0, 8'h00);
    chk("R5 kbd disabled irq", {7'b0, irqKbd}, 8'h00);
    cmd(8'hAE);
    chk("R5 kbd enabled irq", {7'b0, irqKbd}, 8'h01);
    rd(0, 8'h22, "R5 byte");
    cmd(8'hA7); cmd(8'h20); rd(0, 8'h23, "R5 aux disable bit");
    cmd(8'hA8); cmd(8'h20); rd(0, 8'h03, "R5 aux enable bit");
    // R8 A20
    cmd(8'hDD);
    chk("R8 a20 low", {7'b0, a20Out}, 8'h00);
    cmd(8'hD0); rd(0, 8'hCD, "R8 outport bit1 clear");
    cmd(8'hDF);
    chk("R8 a20 high", {7'b0, a20Out}, 8'h01);
    cmd(8'hD0); rd(0, 8'hCF, "R8 outport bit1 set");
    // R9 pulses
    cmd(8'hFF); pulseChk(1'b0, "R9 odd pulse none");
    cmd(8'hF1); pulseChk(1'b0, "R9 F1 none");
    cmd(8'hFE); pulseChk(1'b1, "R9 FE pulse");
    cmd(8'hF0); pulseChk(1'b1, "R9 F0 pulse");
    cmd(8'hD1); dwr(8'hCC);
    chk("R8 outport write a20", {7'b0, a20Out}, 8'h00);
    pulseChk(1'b1, "R9 outport reset");
    cmd(8'hD0); rd(0, 8'hCC, "R8 outport written");
    cmd(8'hD1); dwr(8'hCF); pulseChk(1'b0, "R9 outport no reset");
    chk("R8 a20 restored", {7'b0, a20Out}, 8'h01);
    // R10 unsupported
    cmd(8'h12);
    chk("R10 no tx", {6'b0, kbdTxValid, auxTxValid}, 8'h00);
    cmd(8'hB5);
    chk("R10 no pulse", {7'b0, cpuReset}, 8'h00);
    rd(1, 8'h1C, "R10 status kept");
    cmd(8'h20); rd(0, 8'h03, "R10 mode kept");
    cmd(8'hD0); rd(0, 8'hCF, "R10 outport kept");
    dwr(8'hAB);
    chk("R10 no redirect armed", {6'b0, kbdTxValid, auxTxValid}, 8'h02);
    repeat (2) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule